// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Sequencer

This block runs one hardware-timed capture into an external circular sample buffer. Software first sets the configuration inputs and pulses `arm_i`. The sequencer then waits for an active edge on the start trigger. After a programmable delay it derives a sample strobe from the clock, which serves as the timebase, divided by a programmable ratio. Each strobe produces one registered write of the current input word, with its buffer address. A level-sensitive pause input freezes the divider while it is at its active level.

In reference mode the write pointer wraps around the buffer while the sequencer waits for a reference-trigger edge. Such an edge counts only after a minimum number of pretrigger samples has been written. Once an edge is accepted, the sequencer writes a set number of posttrigger samples and then stops. It raises `done_o` and presents the buffer address of the first posttrigger sample. In posttrigger-only mode it writes the posttrigger count right after the start trigger. `abort_i` returns the sequencer to idle from any state.

Top module: `acq_seq`

## Requirements
- R1: After reset, `wr_en_o`, `done_o` and `trig_addr_o` are all 0, and no strobe occurs until the sequencer is armed and started.
- R2: After an arm pulse the sequencer writes nothing until the start input shows its active edge. `cfg_start_fall_i` = 0 selects the rising edge and 1 selects the falling edge. Edges are found against the value of the previous clock, which resets to 0.
- R3: When the start edge is sampled on clock edge k, the first `wr_en_o` pulse appears after clock edge k + `cfg_delay_i` + 1, provided pause is inactive.
- R4: Strobes are spaced `cfg_div_i` clocks apart. A ratio of 0 or 1 acts as 2, so `wr_en_o` is never high on two consecutive clocks.
- R5: While `pause_i` equals `cfg_pause_pol_i`, the divider and the delay counter hold their values and no strobe is produced. Counting resumes from the held value when the pause ends.
- R6: After arm the write address starts at 0 and rises by 1 per strobe, modulo 2^AW. `wr_data_o` carries the value of `sample_i` on the clock where the strobe was generated.
- R7: With `cfg_ref_en_i` = 1, a reference edge is ignored while fewer than `cfg_pre_i` samples have been written since the start. The edge polarity is set by `cfg_ref_fall_i`, with 0 for rising and 1 for falling.
- R8: After an accepted reference edge, exactly `cfg_post_i` further samples are written. A strobe on the acceptance clock counts as the first of them. Then `done_o` rises and stays high, and no more strobes follow.
- R9: With `cfg_ref_en_i` = 0, exactly `cfg_post_i` samples are written after the start edge, and then `done_o` rises.
- R10: While `done_o` is high, `trig_addr_o` holds the buffer address of the first posttrigger sample; in posttrigger-only mode this is 0. While `done_o` is low, `trig_addr_o` reads 0.
- R11: An arm pulse while done clears `done_o` on the next clock and starts a new capture from address 0.
- R12: `abort_i` clears `done_o` and returns the sequencer to idle on the next clock from any state. No strobe follows the abort clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also used as the sample timebase |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Pulse that arms a new capture (from idle or done) |
| abort_i | input | 1 | Synchronous return to idle |
| cfg_ref_en_i | input | 1 | 1: reference-trigger mode, 0: posttrigger-only |
| cfg_start_fall_i | input | 1 | Start edge select, 1 = falling |
| cfg_ref_fall_i | input | 1 | Reference edge select, 1 = falling |
| cfg_pause_pol_i | input | 1 | Level of `pause_i` that pauses |
| cfg_div_i | input | CW | Timebase clocks per sample (min 2) |
| cfg_delay_i | input | CW | Timebase clocks from start to first sample |
| cfg_pre_i | input | NW | Minimum pretrigger samples |
| cfg_post_i | input | NW | Posttrigger samples |
| start_i | input | 1 | Start trigger line |
| ref_i | input | 1 | Reference trigger line |
| pause_i | input | 1 | Pause trigger line |
| sample_i | input | DW | Sample word |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | AW | Buffer write address |
| wr_data_o | output | DW | Buffer write data |
| trig_addr_o | output | AW | Address of first posttrigger sample, valid with done |
| done_o | output | 1 | Capture complete |

## Verification
A wrong divider or delay count moves the next `wr_en_o` pulse by at least one clock. A per-clock comparison against a behavioural model exposes this at the first strobe after the error. A wrong pointer or pretrigger count shows up in `wr_addr_o` on the next write, or later in `trig_addr_o` and in when `done_o` rises. A missed transition of the state register shows up as strobes that continue or stop when they should not, within one sample period.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_POST,
    ST_DONE
  } acq_state_e;
endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic fall_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign edge_o = fall_i ? (prev_q & ~sig_i) : (sig_i & ~prev_q);
endmodule

// File: rtl/acq_sclk_gen.sv
module acq_sclk_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [CW-1:0] delay_i,
  input  logic [CW-1:0] div_i,
  input  logic          pause_i,
  output logic          tick_o
);
  localparam logic [CW-1:0] MIN_DIV = CW'(2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  assign reload = ((div_i < MIN_DIV) ? MIN_DIV : div_i) - 1'b1;
  assign tick_o = run_i && !pause_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= '0;
    else if (load_i)           cnt_q <= delay_i;
    else if (run_i && !pause_i) cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_seq_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          abort_i,
  input  logic          ref_en_i,
  input  logic [NW-1:0] pre_i,
  input  logic [NW-1:0] post_i,
  input  logic          start_edge_i,
  input  logic          ref_edge_i,
  input  logic          tick_i,
  input  logic [DW-1:0] sample_i,
  output logic          run_o,
  output logic          load_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] trig_addr_o,
  output logic          done_o
);
  localparam logic [NW-1:0] ONE = NW'(1);

  acq_state_e    state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] trig_q, trig_d;
  logic [NW-1:0] cap_q, cap_d;
  logic [NW-1:0] left_q, left_d;
  logic [NW-1:0] post_rem;

  assign run_o    = (state_q == ST_PRE) || (state_q == ST_POST);
  assign load_o   = (state_q == ST_WAIT) && start_edge_i && !abort_i;
  assign post_rem = post_i - (tick_i ? ONE : '0);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    trig_d  = trig_q;
    cap_d   = cap_q;
    left_d  = left_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (arm_i) begin
          state_d = ST_WAIT;
          ptr_d   = '0;
          cap_d   = '0;
          trig_d  = '0;
        end
      end
      ST_WAIT: begin
        if (start_edge_i) begin
          if (ref_en_i) begin
            state_d = ST_PRE;
          end else if (post_i == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_POST;
            left_d  = post_i;
          end
        end
      end
      ST_PRE: begin
        if (tick_i) begin
          ptr_d = ptr_q + 1'b1;
          if (cap_q < pre_i) cap_d = cap_q + 1'b1;
        end
        if (ref_edge_i && (cap_q >= pre_i)) begin
          trig_d = ptr_q;
          if ((post_i == '0) || (post_rem == '0)) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_POST;
            left_d  = post_rem;
          end
        end
      end
      ST_POST: begin
        if (tick_i) begin
          ptr_d  = ptr_q + 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == ONE) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      trig_q    <= '0;
      cap_q     <= '0;
      left_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      trig_q  <= trig_d;
      cap_q   <= cap_d;
      left_q  <= left_d;
      wr_en_o <= tick_i && !abort_i;
      if (tick_i && !abort_i) begin
        wr_addr_o <= ptr_q;
        wr_data_o <= sample_i;
      end
    end
  end

  assign done_o      = (state_q == ST_DONE);
  assign trig_addr_o = done_o ? trig_q : '0;

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (state_q == ST_IDLE) && !done_o); // R12
  AST_REF_GATED: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_POST) && ($past(state_q) == ST_PRE)) |-> $past(cap_q >= pre_i)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !abort_i && !arm_i) |=> done_o); // R8
  AST_WR_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(run_o)); // R2
endmodule

// File: rtl/acq_seq.sv
module acq_seq #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          abort_i,
  input  logic          cfg_ref_en_i,
  input  logic          cfg_start_fall_i,
  input  logic          cfg_ref_fall_i,
  input  logic          cfg_pause_pol_i,
  input  logic [CW-1:0] cfg_div_i,
  input  logic [CW-1:0] cfg_delay_i,
  input  logic [NW-1:0] cfg_pre_i,
  input  logic [NW-1:0] cfg_post_i,
  input  logic          start_i,
  input  logic          ref_i,
  input  logic          pause_i,
  input  logic [DW-1:0] sample_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] trig_addr_o,
  output logic          done_o
);
  localparam int NTRIG = 2;

  logic [NTRIG-1:0] trig_raw, trig_fall, trig_edge;
  logic run, load, tick, paused;

  assign trig_raw  = {ref_i, start_i};
  assign trig_fall = {cfg_ref_fall_i, cfg_start_fall_i};
  assign paused    = (pause_i == cfg_pause_pol_i);

  for (genvar g = 0; g < NTRIG; g++) begin : g_edge
    acq_edge_det u_det (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (trig_raw[g]),
      .fall_i (trig_fall[g]),
      .edge_o (trig_edge[g])
    );
  end

  acq_sclk_gen #(.CW(CW)) u_sclk (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .load_i  (load),
    .delay_i (cfg_delay_i),
    .div_i   (cfg_div_i),
    .pause_i (paused),
    .tick_o  (tick)
  );

  acq_ctrl #(.AW(AW), .DW(DW), .NW(NW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .arm_i        (arm_i),
    .abort_i      (abort_i),
    .ref_en_i     (cfg_ref_en_i),
    .pre_i        (cfg_pre_i),
    .post_i       (cfg_post_i),
    .start_edge_i (trig_edge[0]),
    .ref_edge_i   (trig_edge[1]),
    .tick_i       (tick),
    .sample_i     (sample_i),
    .run_o        (run),
    .load_o       (load),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .trig_addr_o  (trig_addr_o),
    .done_o       (done_o)
  );

  AST_PAUSE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (paused && $past(paused) && !$past(paused, 2) == 1'b0 && $past(!rst, 2)) |-> !wr_en_o); // R5
endmodule

// File: tb/tb_acq_seq.sv
`timescale 1ns/100ps
module tb_acq_seq;
  localparam int AW = 5, DW = 16, CW = 16, NW = 16, DEPTH = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, arm_i, abort_i, cfg_ref_en_i, cfg_start_fall_i, cfg_ref_fall_i, cfg_pause_pol_i;
  logic [CW-1:0] cfg_div_i, cfg_delay_i;
  logic [NW-1:0] cfg_pre_i, cfg_post_i;
  logic start_i, ref_i, pause_i;
  logic [DW-1:0] sample_i;
  logic wr_en_o, done_o;
  logic [AW-1:0] wr_addr_o, trig_addr_o;
  logic [DW-1:0] wr_data_o;

  acq_seq #(.AW(AW), .DW(DW), .CW(CW), .NW(NW)) dut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .abort_i(abort_i),
    .cfg_ref_en_i(cfg_ref_en_i), .cfg_start_fall_i(cfg_start_fall_i),
    .cfg_ref_fall_i(cfg_ref_fall_i), .cfg_pause_pol_i(cfg_pause_pol_i),
    .cfg_div_i(cfg_div_i), .cfg_delay_i(cfg_delay_i), .cfg_pre_i(cfg_pre_i),
    .cfg_post_i(cfg_post_i), .start_i(start_i), .ref_i(ref_i), .pause_i(pause_i),
    .sample_i(sample_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .trig_addr_o(trig_addr_o), .done_o(done_o)
  );

  int tests = 0, fails = 0, cyc = 0;
  string req = "R1";
  int n_strobe = 0, first_cyc = -1, b2b = 0;
  bit prev_wen = 0;

  // behavioural reference model
  int ms = 0, mcnt = 0, mptr = 0, mcap = 0, mleft = 0, mtrig = 0;
  int m_wen = 0, m_waddr = 0, m_wdata = 0, prev_s = 0, prev_r = 0;

  task automatic chk(input string r, input bit ok, input int act, input int exp, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) sample_i <= sample_i + 16'h1357;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ms = 0; mcnt = 0; mptr = 0; mcap = 0; mleft = 0; mtrig = 0;
      m_wen = 0; m_waddr = 0; m_wdata = 0; prev_s = 0; prev_r = 0;
    end else begin
      int divf, optr, need;
      bit se, re, paused, running, tk, ok;
      se = cfg_start_fall_i ? (prev_s == 1 && !start_i) : (start_i && prev_s == 0);
      re = cfg_ref_fall_i ? (prev_r == 1 && !ref_i) : (ref_i && prev_r == 0);
      paused = (pause_i == cfg_pause_pol_i);
      running = (ms == 2 || ms == 3);
      tk = running && !paused && mcnt == 0;
      m_wen = (tk && !abort_i) ? 1 : 0;
      if (m_wen == 1) begin m_waddr = mptr; m_wdata = int'(sample_i); end
      divf = (cfg_div_i < 2) ? 2 : int'(cfg_div_i);
      if (running && !paused) mcnt = (mcnt == 0) ? divf - 1 : mcnt - 1;
      if (abort_i) ms = 0;
      else case (ms)
        0, 4: if (arm_i) begin ms = 1; mptr = 0; mcap = 0; mtrig = 0; end
        1: if (se) begin
             mcnt = int'(cfg_delay_i);
             if (cfg_ref_en_i) ms = 2;
             else if (cfg_post_i == 0) ms = 4;
             else begin ms = 3; mleft = int'(cfg_post_i); end
           end
        2: begin
             ok = re && (mcap >= int'(cfg_pre_i));
             optr = mptr;
             if (tk) begin
               mptr = (mptr + 1) % DEPTH;
               if (mcap < int'(cfg_pre_i)) mcap++;
             end
             if (ok) begin
               mtrig = optr;
               need = int'(cfg_post_i) - (tk ? 1 : 0);
               if (cfg_post_i == 0 || need == 0) ms = 4;
               else begin ms = 3; mleft = need; end
             end
           end
        3: if (tk) begin
             mptr = (mptr + 1) % DEPTH;
             mleft--;
             if (mleft == 0) ms = 4;
           end
        default: ms = 0;
      endcase
      prev_s = start_i; prev_r = ref_i;
    end
    if (cyc > 150000) begin
      chk("WATCHDOG", 0, cyc, 150000, "run hung");
      report();
    end
  end

  // per-clock comparison against the model, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(req, wr_en_o == m_wen[0], int'(wr_en_o), m_wen, "wr_en_o");
      chk(req, done_o == (ms == 4), int'(done_o), int'(ms == 4), "done_o");
      chk(req, int'(trig_addr_o) == ((ms == 4) ? mtrig : 0), int'(trig_addr_o),
          (ms == 4) ? mtrig : 0, "trig_addr_o");
      if (wr_en_o && m_wen == 1) begin
        chk(req, int'(wr_addr_o) == m_waddr, int'(wr_addr_o), m_waddr, "wr_addr_o");
        chk(req, int'(wr_data_o) == m_wdata, int'(wr_data_o), m_wdata, "wr_data_o");
      end
      if (wr_en_o) begin
        n_strobe++;
        if (first_cyc < 0) first_cyc = cyc;
        if (prev_wen) b2b++;
      end
      prev_wen = wr_en_o;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic arm_pulse();
    n_strobe = 0; first_cyc = -1;
    arm_i = 1; step(); arm_i = 0;
  endtask

  task automatic wait_strobes(input int n);
    int g = 0;
    while (n_strobe < n && g < 5000) begin step(); g++; end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done_o && g < 5000) begin step(); g++; end
    chk(req, done_o, int'(done_o), 1, "done reached");
  endtask

  initial begin
    int exp_first, held;
    rst = 1; arm_i = 0; abort_i = 0; cfg_ref_en_i = 0; cfg_start_fall_i = 0;
    cfg_ref_fall_i = 0; cfg_pause_pol_i = 1; cfg_div_i = 2; cfg_delay_i = 0;
    cfg_pre_i = 0; cfg_post_i = 1; start_i = 0; ref_i = 0; pause_i = 0; sample_i = 16'h00a5;
    step(5); rst = 0; step();
    req = "R1";
    chk("R1", !wr_en_o && !done_o && trig_addr_o == 0, int'(done_o), 0, "reset state");
    start_i = 1; step(3); start_i = 0; step(2);
    chk("R1", n_strobe == 0, n_strobe, 0, "no strobe before arm");

    // posttrigger-only, rising start, delay 3, ratio 2
    req = "R2"; cfg_delay_i = 3; cfg_post_i = 5;
    arm_pulse();
    ref_i = 1; step(); ref_i = 0; step(6);
    chk("R2", n_strobe == 0, n_strobe, 0, "no strobe before start edge");
    req = "R3";
    start_i = 1; exp_first = cyc + 1 + 3 + 1;
    wait_done(); start_i = 0;
    chk("R3", first_cyc == exp_first, first_cyc, exp_first, "first strobe timing");
    chk("R9", n_strobe == 5, n_strobe, 5, "posttrigger-only sample count");
    chk("R10", trig_addr_o == 0, int'(trig_addr_o), 0, "trig addr in posttrigger-only mode");
    step(10);
    chk("R8", done_o && n_strobe == 5, n_strobe, 5, "no strobes after done");

    // re-arm from done
    req = "R11";
    arm_pulse();
    chk("R11", !done_o, int'(done_o), 0, "arm clears done");
    abort_i = 1; step(); abort_i = 0;

    // reference mode, falling start, ratio 4, early reference ignored
    req = "R7"; cfg_ref_en_i = 1; cfg_start_fall_i = 1; cfg_div_i = 4; cfg_delay_i = 0;
    cfg_pre_i = 4; cfg_post_i = 3;
    start_i = 1; step(2);
    arm_pulse();
    start_i = 0;
    wait_strobes(1);
    ref_i = 1; step(); ref_i = 0;
    wait_strobes(6);
    chk("R7", !done_o, int'(done_o), 0, "early reference ignored");
    ref_i = 1; step(); ref_i = 0;
    req = "R8";
    wait_done();
    chk("R8", n_strobe == 9, n_strobe, 9, "posttrigger count after reference");
    chk("R10", trig_addr_o == 6, int'(trig_addr_o), 6, "trigger address");

    // pause, active-low polarity, ratio 3
    req = "R5"; cfg_ref_en_i = 0; cfg_start_fall_i = 0; cfg_pause_pol_i = 0; pause_i = 1;
    cfg_div_i = 3; cfg_delay_i = 1; cfg_post_i = 8;
    arm_pulse();
    start_i = 1; wait_strobes(2);
    pause_i = 0; step(2); held = n_strobe; step(10);
    chk("R5", n_strobe == held, n_strobe, held, "no strobes while paused");
    pause_i = 1;
    wait_done(); start_i = 0;
    chk("R5", n_strobe == 8, n_strobe, 8, "all samples after resume");

    // wrap of the write pointer, falling reference edge
    req = "R6"; cfg_ref_en_i = 1; cfg_ref_fall_i = 1; cfg_div_i = 2; cfg_delay_i = 0;
    cfg_pre_i = 2; cfg_post_i = 4; ref_i = 1;
    arm_pulse();
    start_i = 1; wait_strobes(40);
    ref_i = 0; step(); ref_i = 1;
    wait_done(); start_i = 0;
    chk("R6", n_strobe == 44, n_strobe, 44, "strobe count with wrap");
    chk("R6", wr_addr_o == 11, int'(wr_addr_o), 11, "last address after wrap");
    chk("R10", trig_addr_o == 8, int'(trig_addr_o), 8, "wrapped trigger address");
    ref_i = 0;

    // ratio below 2 acts as 2
    req = "R4"; cfg_ref_en_i = 0; cfg_div_i = 1; cfg_post_i = 6; b2b = 0;
    arm_pulse();
    start_i = 1; wait_done(); start_i = 0;
    chk("R4", b2b == 0, b2b, 0, "no back-to-back strobes, ratio 1");
    cfg_div_i = 0; b2b = 0;
    arm_pulse();
    start_i = 1; wait_done(); start_i = 0;
    chk("R4", b2b == 0 && n_strobe == 6, n_strobe, 6, "ratio 0 behaves as 2");

    // abort mid-run and from done
    req = "R12"; cfg_ref_en_i = 1; cfg_ref_fall_i = 0; cfg_div_i = 2; cfg_pre_i = 1; cfg_post_i = 20;
    arm_pulse();
    start_i = 1; wait_strobes(3);
    abort_i = 1; step(); abort_i = 0; step();
    held = n_strobe; step(12);
    chk("R12", n_strobe == held && !done_o, n_strobe, held, "no strobes after abort");
    start_i = 0;
    cfg_ref_en_i = 0; cfg_post_i = 2;
    arm_pulse(); step(); start_i = 1; wait_done(); start_i = 0;
    abort_i = 1; step(); abort_i = 0;
    chk("R12", !done_o && trig_addr_o == 0, int'(done_o), 0, "abort clears done");
    step(4);
    report();
  end
endmodule